// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central bookkeeping unit of a dynamically scheduled execution core. Decoded instructions arrive in program order on a valid/ready port. Each instruction carries a unit class, a destination register and two source registers. The controller owns five non-pipelined functional units: one integer/memory unit, two multipliers, one adder and one divider. It steps every instruction through four stages: issue, operand read, execute and result write. Instructions enter in order, but they may read operands, execute and retire out of order.

Each functional unit is a slot with its own state machine. The states are `SL_IDLE` (free), `SL_WAIT` (issued and waiting for operands), `SL_EXEC` (counting down its latency) and `SL_DONE` (finished and waiting for permission to write). The transitions are:
- *issue* (`SL_IDLE`→`SL_WAIT`)
- *read* (`SL_WAIT`→`SL_EXEC`, when both source-ready flags are set)
- *finish* (`SL_EXEC`→`SL_DONE`, when the countdown reaches its last cycle)
- *write* (`SL_DONE`→`SL_IDLE`, on a write grant)

A producer table records, for each architectural register, which unit will write it next. Register data, caches and branches are handled elsewhere. The outputs are the operand-read grants (a read grant also starts execution), the write grants, the per-unit busy flags and the producer table.

Top module: `sb_ctrl`

## Requirements
- R1: `in_ready` is high exactly when two conditions hold: some unit of the requested class is in `SL_IDLE`, and the producer entry of `in_dst` is empty. Class codes on `in_cls` are 0 integer/memory, 1 multiply, 2 add, 3 divide. Units are numbered 0 integer, 1 and 2 multiply, 3 add, 4 divide. An accepted instruction goes to the lowest-numbered idle unit of its class.
- R2: While a structural or WAW hazard holds back the instruction at the port, `in_ready` stays low and nothing is accepted. Issue therefore remains in program order.
- R3: The clock edge that accepts an instruction sets the unit's busy bit. The same edge writes unit number + 1 into the producer entry of its destination. Entry value 0 means no pending writer. Entry r occupies bits [3r+2:3r] of `prod_o`.
- R4: A busy unit raises its `rd_grant` bit for one cycle once both of its sources are ready. The earliest such cycle is the first cycle after acceptance. A later instruction may read before an earlier one that is still waiting.
- R5: A source is ready at acceptance if its register has no pending writer, or if that writer receives its write grant in the same cycle. Otherwise the source becomes ready through the write broadcast, and the unit may read in the cycle after that writer's grant. Both ready flags drop after the read.
- R6: Execution lasts 1, 10, 2 and 40 cycles for integer, multiply, add and divide. A unit whose read grant is in cycle t may receive a write grant no earlier than cycle t + latency + 1.
- R7: A finished unit is denied its write while another unit waiting for operands holds a ready flag on a source equal to the finished unit's destination (WAR).
- R8: At most one write grant is given per cycle, and it goes to the lowest-numbered eligible unit.
- R9: The edge after a write grant clears that unit's busy bit and its destination's producer entry. The freed unit can accept a new instruction from the next cycle.
- R10: A synchronous reset clears all busy bits and all producer entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered at the issue port |
| in_ready | output | 1 | Issue port can accept this cycle |
| in_cls | input | 2 | Unit class of the offered instruction |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| rd_grant | output | 5 | Per-unit operand read / execution start pulse |
| wr_grant | output | 5 | Per-unit result write pulse, at most one bit set |
| busy_o | output | 5 | Per-unit busy flags |
| prod_o | output | 96 | Producer table, 3 bits per register |

## Verification
Timing of each result:
- `in_ready` and both grant vectors are combinational over state registered at the previous edge, so each is judged in the cycle it appears.
- A read grant can come no sooner than one cycle after the accepting edge.
- A write grant comes latency + 1 cycles after the read grant, and a waiting read follows a write grant by one cycle.
- Busy bits and producer entries move on the edge that ends the accepting or writing cycle.

Sampling: the bench samples every output 1 ns after the falling edge and compares it with an expected value from its own model. The model advances exactly once per cycle, in the order writes, then reads, then issue. A grant that comes a cycle early or late therefore shows up as a mismatch in that very cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_ADD = 2'd2,
        CLS_DIV = 2'd3
    } fu_cls_e;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_WAIT = 2'd1,
        SL_EXEC = 2'd2,
        SL_DONE = 2'd3
    } slot_st_e;

    // Units are laid out by class: integer first, then multiply, add, divide.
    function automatic fu_cls_e cls_of_unit(int u, int n_int, int n_mul, int n_add);
        if (u < n_int)                    return CLS_INT;
        else if (u < n_int + n_mul)       return CLS_MUL;
        else if (u < n_int + n_mul + n_add) return CLS_ADD;
        else                              return CLS_DIV;
    endfunction

endpackage

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int REGW = 5,
    parameter int TAGW = 3,
    parameter int CNTW = 6,
    parameter int LAT  = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_en,
    input  logic [REGW-1:0] iss_dst,
    input  logic [REGW-1:0] iss_s1,
    input  logic [REGW-1:0] iss_s2,
    input  logic            iss_r1,
    input  logic            iss_r2,
    input  logic [TAGW-1:0] iss_q1,
    input  logic [TAGW-1:0] iss_q2,
    input  logic            wb_any,
    input  logic [TAGW-1:0] wb_tag,
    input  logic            wb_me,
    output logic            busy,
    output logic            waiting,
    output logic            done,
    output logic            rd_go,
    output logic [REGW-1:0] dst,
    output logic [REGW-1:0] s1,
    output logic [REGW-1:0] s2,
    output logic            r1,
    output logic            r2
);

    slot_st_e        st, st_nx;
    logic [CNTW-1:0] cnt;
    logic [TAGW-1:0] q1, q2;

    // next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            SL_IDLE: if (issue_en)      st_nx = SL_WAIT;
            SL_WAIT: if (r1 && r2)      st_nx = SL_EXEC;
            SL_EXEC: if (cnt == CNTW'(1)) st_nx = SL_DONE;
            SL_DONE: if (wb_me)         st_nx = SL_IDLE;
            default:                    st_nx = SL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= SL_IDLE;
        else     st <= st_nx;
    end

    // outputs
    always_comb begin
        busy    = (st != SL_IDLE);
        waiting = (st == SL_WAIT);
        done    = (st == SL_DONE);
        rd_go   = (st == SL_WAIT) && r1 && r2;
    end

    // latency countdown
    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (rd_go)          cnt <= CNTW'(LAT);
        else if (st == SL_EXEC)  cnt <= cnt - CNTW'(1);
    end

    // entry fields: registers, producers, ready flags
    always_ff @(posedge clk) begin
        if (rst) begin
            dst <= '0; s1 <= '0; s2 <= '0;
            r1  <= 1'b0; r2 <= 1'b0; q1 <= '0; q2 <= '0;
        end else if (issue_en) begin
            dst <= iss_dst; s1 <= iss_s1; s2 <= iss_s2;
            r1  <= iss_r1;  r2 <= iss_r2; q1 <= iss_q1; q2 <= iss_q2;
        end else if (st == SL_WAIT) begin
            if (r1 && r2) begin
                r1 <= 1'b0;
                r2 <= 1'b0;
            end else begin
                if (wb_any && !r1 && q1 == wb_tag) begin r1 <= 1'b1; q1 <= '0; end
                if (wb_any && !r2 && q2 == wb_tag) begin r2 <= 1'b1; q2 <= '0; end
            end
        end
    end

    a_r3_issue_into_idle: assert property (@(posedge clk) disable iff (rst)
        issue_en |-> st == SL_IDLE);
    a_r5_flags_drop_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> (st == SL_EXEC && !r1 && !r2));
    a_r6_done_from_exec: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(st) == SL_EXEC);
    a_r9_free_after_write: assert property (@(posedge clk) disable iff (rst)
        wb_me |=> st == SL_IDLE);
    a_r8_grant_only_when_done: assert property (@(posedge clk) disable iff (rst)
        wb_me |-> st == SL_DONE);

endmodule

// File: rtl/sb_issue.sv
module sb_issue
    import sb_pkg::*;
#(
    parameter int NFU   = 5,
    parameter int N_INT = 1,
    parameter int N_MUL = 2,
    parameter int N_ADD = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  fu_cls_e        in_cls,
    input  logic [NFU-1:0] busy,
    input  logic           waw,
    output logic           in_ready,
    output logic [NFU-1:0] issue_vec
);

    logic [NFU-1:0] sel;
    logic           found;

    // lowest idle unit of the requested class
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int u = 0; u < NFU; u++) begin
            if (!found && !busy[u] && cls_of_unit(u, N_INT, N_MUL, N_ADD) == in_cls) begin
                sel[u] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign in_ready  = found && !waw;
    assign issue_vec = (in_valid && in_ready) ? sel : '0;

    a_r1_single_issue: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_vec));
    a_r2_hold_on_waw: assert property (@(posedge clk) disable iff (rst)
        waw |-> issue_vec == '0);

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
    parameter int NFU  = 5,
    parameter int REGW = 5,
    parameter int TAGW = 3
) (
    input  logic [NFU-1:0]           done,
    input  logic [NFU-1:0]           waiting,
    input  logic [NFU-1:0][REGW-1:0] dst,
    input  logic [NFU-1:0][REGW-1:0] s1,
    input  logic [NFU-1:0][REGW-1:0] s2,
    input  logic [NFU-1:0]           r1,
    input  logic [NFU-1:0]           r2,
    output logic [NFU-1:0]           wr_grant,
    output logic                     wr_any,
    output logic [TAGW-1:0]          wr_tag
);

    logic [NFU-1:0] war;

    // a waiting reader still needs the old value of this unit's destination
    always_comb begin
        war = '0;
        for (int u = 0; u < NFU; u++) begin
            for (int v = 0; v < NFU; v++) begin
                if (v != u && waiting[v] &&
                    ((s1[v] == dst[u] && r1[v]) || (s2[v] == dst[u] && r2[v])))
                    war[u] = 1'b1;
            end
        end
    end

    // lowest-index eligible finisher wins
    always_comb begin
        wr_grant = '0;
        wr_any   = 1'b0;
        wr_tag   = '0;
        for (int u = 0; u < NFU; u++) begin
            if (!wr_any && done[u] && !war[u]) begin
                wr_grant[u] = 1'b1;
                wr_any      = 1'b1;
                wr_tag      = TAGW'(u + 1);
            end
        end
    end

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int N_INT   = 1,
    parameter int N_MUL   = 2,
    parameter int N_ADD   = 1,
    parameter int N_DIV   = 1,
    parameter int NREG    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 10,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 40
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     in_valid,
    output logic                                     in_ready,
    input  logic [1:0]                               in_cls,
    input  logic [$clog2(NREG)-1:0]                  in_dst,
    input  logic [$clog2(NREG)-1:0]                  in_src1,
    input  logic [$clog2(NREG)-1:0]                  in_src2,
    output logic [N_INT+N_MUL+N_ADD+N_DIV-1:0]       rd_grant,
    output logic [N_INT+N_MUL+N_ADD+N_DIV-1:0]       wr_grant,
    output logic [N_INT+N_MUL+N_ADD+N_DIV-1:0]       busy_o,
    output logic [NREG*$clog2(N_INT+N_MUL+N_ADD+N_DIV+1)-1:0] prod_o
);

    localparam int NFU  = N_INT + N_MUL + N_ADD + N_DIV;
    localparam int REGW = $clog2(NREG);
    localparam int TAGW = $clog2(NFU + 1);
    localparam int LMX1 = (LAT_INT > LAT_MUL) ? LAT_INT : LAT_MUL;
    localparam int LMX2 = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
    localparam int LMAX = (LMX1 > LMX2) ? LMX1 : LMX2;
    localparam int CNTW = $clog2(LMAX + 1);

    logic [TAGW-1:0]           prod_q [NREG];
    logic [NFU-1:0]            issue_vec, waiting, done;
    logic [NFU-1:0][REGW-1:0]  dst_a, s1_a, s2_a;
    logic [NFU-1:0]            r1_a, r2_a;
    logic                      wr_any, waw;
    logic [TAGW-1:0]           wr_tag, iss_tag, p1, p2, iss_q1, iss_q2;
    logic [REGW-1:0]           wr_dst;
    logic                      iss_r1, iss_r2;

    // source readiness at issue, including a same-cycle write
    always_comb begin
        p1     = prod_q[in_src1];
        p2     = prod_q[in_src2];
        iss_r1 = (p1 == '0) || (wr_any && p1 == wr_tag);
        iss_r2 = (p2 == '0) || (wr_any && p2 == wr_tag);
        iss_q1 = iss_r1 ? '0 : p1;
        iss_q2 = iss_r2 ? '0 : p2;
        waw    = (prod_q[in_dst] != '0);
    end

    always_comb begin
        iss_tag = '0;
        wr_dst  = '0;
        for (int u = 0; u < NFU; u++) begin
            if (issue_vec[u]) iss_tag = TAGW'(u + 1);
            if (wr_grant[u])  wr_dst  = dst_a[u];
        end
    end

    sb_issue #(.NFU(NFU), .N_INT(N_INT), .N_MUL(N_MUL), .N_ADD(N_ADD)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_cls    (fu_cls_e'(in_cls)),
        .busy      (busy_o),
        .waw       (waw),
        .in_ready  (in_ready),
        .issue_vec (issue_vec)
    );

    for (genvar g = 0; g < NFU; g++) begin : g_slot
        localparam fu_cls_e C = cls_of_unit(g, N_INT, N_MUL, N_ADD);
        localparam int L = (C == CLS_INT) ? LAT_INT :
                           (C == CLS_MUL) ? LAT_MUL :
                           (C == CLS_ADD) ? LAT_ADD : LAT_DIV;
        sb_fu_slot #(.REGW(REGW), .TAGW(TAGW), .CNTW(CNTW), .LAT(L)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .issue_en (issue_vec[g]),
            .iss_dst  (in_dst),
            .iss_s1   (in_src1),
            .iss_s2   (in_src2),
            .iss_r1   (iss_r1),
            .iss_r2   (iss_r2),
            .iss_q1   (iss_q1),
            .iss_q2   (iss_q2),
            .wb_any   (wr_any),
            .wb_tag   (wr_tag),
            .wb_me    (wr_grant[g]),
            .busy     (busy_o[g]),
            .waiting  (waiting[g]),
            .done     (done[g]),
            .rd_go    (rd_grant[g]),
            .dst      (dst_a[g]),
            .s1       (s1_a[g]),
            .s2       (s2_a[g]),
            .r1       (r1_a[g]),
            .r2       (r2_a[g])
        );
    end

    sb_wb_arb #(.NFU(NFU), .REGW(REGW), .TAGW(TAGW)) u_arb (
        .done     (done),
        .waiting  (waiting),
        .dst      (dst_a),
        .s1       (s1_a),
        .s2       (s2_a),
        .r1       (r1_a),
        .r2       (r2_a),
        .wr_grant (wr_grant),
        .wr_any   (wr_any),
        .wr_tag   (wr_tag)
    );

    // register producer table
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) prod_q[r] <= '0;
        end else begin
            if (wr_any)        prod_q[wr_dst] <= '0;
            if (issue_vec != '0) prod_q[in_dst] <= iss_tag;
        end
    end

    always_comb begin
        for (int r = 0; r < NREG; r++) prod_o[r*TAGW +: TAGW] = prod_q[r];
    end

    a_r3_producer_recorded: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> prod_q[$past(in_dst)] != '0);
    a_r9_producer_cleared: assert property (@(posedge clk) disable iff (rst)
        wr_any |=> prod_q[$past(wr_dst)] == '0);
    a_r8_one_writer: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_grant));
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> busy_o == '0);

endmodule

// File: tb/test_sb_ctrl.sv
module test_sb_ctrl;

    localparam int NFU   = 5;
    localparam int NREG  = 32;
    localparam int REGW  = 5;
    localparam int TAGW  = 3;
    localparam int NPROG = 300;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                   rst, in_valid, in_ready;
    logic [1:0]             in_cls;
    logic [REGW-1:0]        in_dst, in_src1, in_src2;
    logic [NFU-1:0]         rd_grant, wr_grant, busy;
    logic [NREG*TAGW-1:0]   prod_tab;

    sb_ctrl i_sb_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .rd_grant(rd_grant), .wr_grant(wr_grant), .busy_o(busy), .prod_o(prod_tab)
    );

    int checks = 0, errors = 0, cyc = 0;
    int p_cls[NPROG], p_dst[NPROG], p_s1[NPROG], p_s2[NPROG];
    bit m_busy[NFU], m_rd[NFU], m_pd1[NFU], m_pd2[NFU];
    int m_rdc[NFU], m_dst[NFU], m_s1[NFU], m_s2[NFU], m_q1[NFU], m_q2[NFU];
    int m_prod[NREG];
    bit accepted;

    function automatic int cls_of(int u);
        return (u == 0) ? 0 : (u <= 2) ? 1 : (u == 3) ? 2 : 3;
    endfunction

    function automatic int lat_of(int u);
        int c = cls_of(u);
        return (c == 0) ? 1 : (c == 1) ? 10 : (c == 2) ? 2 : 40;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < NFU; u++) begin
            m_busy[u] = 0; m_rd[u] = 0; m_pd1[u] = 0; m_pd2[u] = 0;
            m_rdc[u] = 0; m_q1[u] = -1; m_q2[u] = -1;
        end
        for (int r = 0; r < NREG; r++) m_prod[r] = -1;
    endtask

    // called just after a falling edge with this cycle's inputs applied
    task automatic cycle();
        logic [NFU-1:0]       e_rd, e_wr, e_busy;
        logic [NREG*TAGW-1:0] e_prod;
        bit                   e_ready;
        int                   pick, w;
        #1;
        for (int u = 0; u < NFU; u++) e_busy[u] = m_busy[u];
        for (int r = 0; r < NREG; r++)
            e_prod[r*TAGW +: TAGW] = (m_prod[r] < 0) ? '0 : TAGW'(m_prod[r] + 1);
        pick = -1;
        for (int u = 0; u < NFU; u++)
            if (pick < 0 && !m_busy[u] && cls_of(u) == int'(in_cls)) pick = u;
        e_ready = (pick >= 0) && (m_prod[in_dst] < 0);
        for (int u = 0; u < NFU; u++)
            e_rd[u] = m_busy[u] && !m_rd[u] && !m_pd1[u] && !m_pd2[u];
        w = -1;
        for (int u = 0; u < NFU; u++) begin
            if (w < 0 && m_busy[u] && m_rd[u] && cyc >= m_rdc[u] + lat_of(u) + 1) begin
                bit war = 0;
                for (int v = 0; v < NFU; v++)
                    if (v != u && m_busy[v] && !m_rd[v] &&
                        ((m_s1[v] == m_dst[u] && !m_pd1[v]) || (m_s2[v] == m_dst[u] && !m_pd2[v])))
                        war = 1;
                if (!war) w = u;
            end
        end
        e_wr = '0;
        if (w >= 0) e_wr[w] = 1'b1;

        chk("R1 R2", "in_ready", 128'(in_ready), 128'(e_ready));
        chk("R4 R5", "rd_grant", 128'(rd_grant), 128'(e_rd));
        chk("R6 R7 R8", "wr_grant", 128'(wr_grant), 128'(e_wr));
        chk("R3 R9", "busy", 128'(busy), 128'(e_busy));
        chk("R3 R9", "producer table", 128'(prod_tab), 128'(e_prod));

        // model update: write, then read, then issue
        if (w >= 0) begin
            m_busy[w] = 0;
            m_prod[m_dst[w]] = -1;
            for (int v = 0; v < NFU; v++) begin
                if (m_busy[v] && !m_rd[v] && m_q1[v] == w) m_pd1[v] = 0;
                if (m_busy[v] && !m_rd[v] && m_q2[v] == w) m_pd2[v] = 0;
            end
        end
        for (int u = 0; u < NFU; u++)
            if (e_rd[u]) begin m_rd[u] = 1; m_rdc[u] = cyc; end
        accepted = in_valid && e_ready;
        if (accepted) begin
            m_busy[pick] = 1; m_rd[pick] = 0;
            m_dst[pick] = int'(in_dst); m_s1[pick] = int'(in_src1); m_s2[pick] = int'(in_src2);
            m_q1[pick] = m_prod[in_src1]; m_q2[pick] = m_prod[in_src2];
            m_pd1[pick] = (m_q1[pick] >= 0); m_pd2[pick] = (m_q2[pick] >= 0);
            m_prod[in_dst] = pick;
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic run_prog(input int n, input bit gaps);
        int  idx = 0;
        bit  hold = 0;
        while (idx < n) begin
            if (!hold) in_valid = gaps ? ($urandom % 5 != 0) : 1'b1;
            in_cls  = 2'(p_cls[idx]);
            in_dst  = REGW'(p_dst[idx]);
            in_src1 = REGW'(p_s1[idx]);
            in_src2 = REGW'(p_s2[idx]);
            cycle();
            if (in_valid) begin
                if (accepted) idx++;
                hold = !accepted;
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        bit any = 1;
        in_valid = 1'b0;
        for (int k = 0; k < 600 && any; k++) begin
            cycle();
            any = 0;
            for (int u = 0; u < NFU; u++) if (m_busy[u]) any = 1;
        end
        #1;
        chk("R9", "all units free after drain", 128'(busy), 128'(0));
        @(negedge clk);
        cyc++;
    endtask

    task automatic set_instr(input int i, input int c, input int d, input int a, input int b);
        p_cls[i] = c; p_dst[i] = d; p_s1[i] = a; p_s2[i] = b;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R10", "busy after reset", 128'(busy), 128'(0));
        chk("R10", "producer table after reset", 128'(prod_tab), 128'(0));
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        in_valid = 1'b0; in_cls = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
        @(negedge clk);
        do_reset();

        // directed: load/load/mul/sub/div/add with RAW, WAR and WAW links
        set_instr(0, 0, 6, 20, 20);
        set_instr(1, 0, 2, 21, 21);
        set_instr(2, 1, 0, 2, 4);
        set_instr(3, 2, 8, 6, 2);
        set_instr(4, 3, 10, 0, 6);
        set_instr(5, 2, 6, 8, 2);
        run_prog(6, 1'b0);
        drain();

        // directed R8: add then integer finish in the same cycle, unit 0 first
        set_instr(0, 2, 11, 20, 20);
        set_instr(1, 0, 12, 21, 21);
        run_prog(2, 1'b0);
        drain();

        // directed R2: WAW on the same destination holds the port
        set_instr(0, 1, 5, 20, 21);
        set_instr(1, 0, 5, 22, 22);
        set_instr(2, 0, 7, 5, 5);
        run_prog(3, 1'b0);
        drain();

        // random stream over a small register set to provoke hazards
        for (int i = 0; i < NPROG; i++)
            set_instr(i, int'($urandom % 4), int'($urandom % 8),
                      int'($urandom % 8), int'($urandom % 8));
        run_prog(NPROG, 1'b1);
        drain();

        // R10: reset with work in flight
        run_prog(6, 1'b0);
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule